// File: doc/BRIEF.md
# Coprocessor Data Bus Access Unit

This unit stands between the load/store stage of a coprocessor and the memory system behind it. It serves two independent channels: one for reads and one for writes. Each channel takes a 16-bit word address, a transfer size of 16 or 32 bits, and a valid/ready handshake. A read and a write may be accepted in the same cycle. A 32-bit transfer to an odd word is carried out at the even word below it. Only the address sent to the memory side is changed; the requester's own address is left as it is.

Each memory-side address is mapped to one of four regions, or to none. The regions are an outbox (messages from the coprocessor to the host), an inbox (messages from the host to the coprocessor), local data RAM and shared peripherals. Parameters set the base and size of each region. The read channel may reach all four regions. The write channel may not touch the inbox. When the target region reports a conflict through its ready input, the channel stalls. An access that is unmapped or not permitted never stalls. It is never presented to memory, and it raises a one-cycle error flag. A read of this kind returns zero.

Read data comes back one cycle after the read is accepted. It is taken from the memory data input in that cycle and shaped to the size of the transfer.

Top module: `cdb_access_unit`

## Requirements
- R1: A read and a write can both be accepted in the same clock cycle, and a stall on one channel does not lower the other channel's ready.
- R2: For a 32-bit access, the memory-side address is the requester's address with bit 0 cleared. For a 16-bit access, the memory-side address equals the requester's address, including odd values.
- R3: The region select outputs are one-hot or zero, using bit 0 for outbox, bit 1 for inbox, bit 2 for local RAM and bit 3 for peripherals. A region is hit when base <= aligned address < base + size. With the default parameters these ranges are outbox 0x1480-0x14FF, inbox 0x1500-0x157F, local 0x8000-0x9FFF and peripherals 0x4000-0x5FFF.
- R4: The read channel presents accesses to all four regions on the memory side: mem_rd_valid is high and the matching select bit is set.
- R5: A write to the inbox is never presented to memory: mem_wr_valid stays low and mem_wr_sel stays zero. It is dropped, and wr_err is high during the one cycle after it is accepted.
- R6: While a permitted access is pending and its region's ready input is low, the channel's ready is low, nothing is accepted, no response appears, and the memory-side address is held. A busy region that the access does not target has no effect.
- R7: An unmapped or forbidden access is accepted at once, whatever the target ready inputs are. The matching error output is high for exactly the one cycle after acceptance, and a rejected read returns rd_rvalid with rd_rdata equal to zero.
- R8: rd_rvalid is high during the cycle after a read is accepted, and low otherwise. In that cycle rd_rdata is formed from mem_rd_data.
- R9: A 16-bit read returns mem_rd_data[15:0] in the low half of rd_rdata, with the upper half zero. A 32-bit read returns all 32 bits.
- R10: For a 16-bit write, mem_wr_data carries wr_data[15:0] in the low half and zero in the upper half. For a 32-bit write, it carries wr_data unchanged.
- R11: After reset, rd_rvalid, rd_err and wr_err are low and rd_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Read request pending |
| rd_ready | output | 1 | Read request accepted this cycle when high with rd_valid |
| rd_addr | input | ADDR_W | Read word address |
| rd_wide | input | 1 | 1 = 32-bit read, 0 = 16-bit read |
| rd_rvalid | output | 1 | Read response valid |
| rd_rdata | output | DATA_W | Read response data |
| rd_err | output | 1 | Read was unmapped (one-cycle pulse with the response) |
| wr_valid | input | 1 | Write request pending |
| wr_ready | output | 1 | Write request accepted this cycle when high with wr_valid |
| wr_addr | input | ADDR_W | Write word address |
| wr_wide | input | 1 | 1 = 32-bit write, 0 = 16-bit write |
| wr_data | input | DATA_W | Write data |
| wr_err | output | 1 | Write was unmapped or forbidden (one-cycle pulse) |
| mem_rd_valid | output | 1 | Read presented to a permitted region |
| mem_rd_sel | output | 4 | One-hot read region select |
| mem_rd_addr | output | ADDR_W | Aligned read address |
| mem_rd_wide | output | 1 | Read size toward memory |
| rd_tgt_ready | input | 4 | Per-region read readiness (low = conflict) |
| mem_rd_data | input | DATA_W | Memory read data, valid the cycle after acceptance |
| mem_wr_valid | output | 1 | Write presented to a permitted region |
| mem_wr_sel | output | 4 | One-hot write region select |
| mem_wr_addr | output | ADDR_W | Aligned write address |
| mem_wr_wide | output | 1 | Write size toward memory |
| mem_wr_data | output | DATA_W | Shaped write data |
| wr_tgt_ready | input | 4 | Per-region write readiness (low = conflict) |

## Verification
The hardest case to reach is a stall on one channel while the other keeps moving. It needs a region ready input dropped for exactly the region the read targets, while a write to a different region goes through in the same cycle. The bench holds the local RAM read ready low for several cycles. During that time it checks that the read stays pending with a steady address and gives no response, and that a concurrent write to the outbox is accepted. It then releases the ready input and checks that the response arrives one cycle later. A forbidden write is also issued while every target ready is low, to show that rejected accesses are never stalled by a conflict.

// File: rtl/cdb_pkg.sv
package cdb_pkg;

    localparam int unsigned NREG       = 4;
    localparam int unsigned IDX_OUTBOX = 0;
    localparam int unsigned IDX_INBOX  = 1;
    localparam int unsigned IDX_LOCAL  = 2;
    localparam int unsigned IDX_PERIPH = 3;

    // permitted-region masks, bit per region index
    localparam logic [NREG-1:0] RD_ALLOW = 4'b1111;
    localparam logic [NREG-1:0] WR_ALLOW = 4'b1101;

    typedef struct packed {
        logic rd_rvalid;
        logic rd_err;
        logic rd_wide;
        logic wr_err;
    } rsp_state_t;

endpackage

// File: rtl/cdb_region_decode.sv
module cdb_region_decode
    import cdb_pkg::*;
#(
    parameter int unsigned               AW    = 16,
    parameter logic [NREG*AW-1:0]        BASES = '0,
    parameter logic [NREG*(AW+1)-1:0]    SIZES = '0
) (
    input  logic [AW-1:0]   addr,
    output logic [NREG-1:0] hit
);

    logic [NREG-1:0] raw_hit;

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_range
            localparam logic [AW:0] LO = {1'b0, BASES[g*AW +: AW]};
            localparam logic [AW:0] HI = LO + SIZES[g*(AW+1) +: (AW+1)];
            assign raw_hit[g] = ({1'b0, addr} >= LO) && ({1'b0, addr} < HI);
        end
    endgenerate

    // lowest index wins if parameters overlap, keeping the result one-hot
    always_comb begin
        hit = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (raw_hit[i]) begin
                hit    = '0;
                hit[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/cdb_port.sv
module cdb_port
    import cdb_pkg::*;
#(
    parameter int unsigned            AW    = 16,
    parameter logic [NREG-1:0]        ALLOW = 4'b1111,
    parameter logic [NREG*AW-1:0]     BASES = '0,
    parameter logic [NREG*(AW+1)-1:0] SIZES = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid,
    input  logic [AW-1:0]   addr,
    input  logic            wide,
    input  logic [NREG-1:0] tgt_ready,
    output logic            ready,
    output logic            mem_valid,
    output logic [NREG-1:0] mem_sel,
    output logic [AW-1:0]   mem_addr,
    output logic            accept,
    output logic            fault
);

    logic [AW-1:0]   aligned;
    logic [NREG-1:0] hit;
    logic [NREG-1:0] permitted;
    logic            ok;

    always_comb begin
        aligned = addr;
        if (wide) begin
            aligned[0] = 1'b0;
        end
    end

    cdb_region_decode #(
        .AW    (AW),
        .BASES (BASES),
        .SIZES (SIZES)
    ) u_decode (
        .addr (aligned),
        .hit  (hit)
    );

    always_comb begin
        permitted = hit & ALLOW;
        ok        = |permitted;
        mem_addr  = aligned;
        mem_sel   = ok ? permitted : '0;
        mem_valid = valid && ok;
        ready     = ok ? |(permitted & tgt_ready) : 1'b1;
        accept    = valid && ready;
        fault     = valid && !ok;
    end

    // R3
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mem_sel));

    // R2
    wide_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && wide) |-> !mem_addr[0]);

    // R5
    allow_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_sel & ~ALLOW) == '0);

    // R6
    stall_only_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |-> (mem_valid && !fault));

endmodule

// File: rtl/cdb_access_unit.sv
module cdb_access_unit
    import cdb_pkg::*;
#(
    parameter int unsigned        ADDR_W      = 16,
    parameter int unsigned        DATA_W      = 32,
    parameter logic [ADDR_W-1:0]  OUTBOX_BASE = 16'h1480,
    parameter int unsigned        OUTBOX_SIZE = 128,
    parameter logic [ADDR_W-1:0]  INBOX_BASE  = 16'h1500,
    parameter int unsigned        INBOX_SIZE  = 128,
    parameter logic [ADDR_W-1:0]  LOCAL_BASE  = 16'h8000,
    parameter int unsigned        LOCAL_SIZE  = 8192,
    parameter logic [ADDR_W-1:0]  PERIPH_BASE = 16'h4000,
    parameter int unsigned        PERIPH_SIZE = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    output logic              rd_ready,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_wide,
    output logic              rd_rvalid,
    output logic [DATA_W-1:0] rd_rdata,
    output logic              rd_err,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_wide,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_err,
    output logic              mem_rd_valid,
    output logic [3:0]        mem_rd_sel,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic              mem_rd_wide,
    input  logic [3:0]        rd_tgt_ready,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_valid,
    output logic [3:0]        mem_wr_sel,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic              mem_wr_wide,
    output logic [DATA_W-1:0] mem_wr_data,
    input  logic [3:0]        wr_tgt_ready
);

    localparam int unsigned HALF_W = DATA_W / 2;
    localparam logic [NREG*ADDR_W-1:0] BASES =
        {PERIPH_BASE, LOCAL_BASE, INBOX_BASE, OUTBOX_BASE};
    localparam logic [NREG*(ADDR_W+1)-1:0] SIZES = {
        (ADDR_W+1)'(PERIPH_SIZE), (ADDR_W+1)'(LOCAL_SIZE),
        (ADDR_W+1)'(INBOX_SIZE),  (ADDR_W+1)'(OUTBOX_SIZE)};

    logic rd_accept, rd_fault, wr_accept, wr_fault;

    cdb_port #(
        .AW    (ADDR_W),
        .ALLOW (RD_ALLOW),
        .BASES (BASES),
        .SIZES (SIZES)
    ) u_rd_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (rd_valid),
        .addr      (rd_addr),
        .wide      (rd_wide),
        .tgt_ready (rd_tgt_ready),
        .ready     (rd_ready),
        .mem_valid (mem_rd_valid),
        .mem_sel   (mem_rd_sel),
        .mem_addr  (mem_rd_addr),
        .accept    (rd_accept),
        .fault     (rd_fault)
    );

    cdb_port #(
        .AW    (ADDR_W),
        .ALLOW (WR_ALLOW),
        .BASES (BASES),
        .SIZES (SIZES)
    ) u_wr_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (wr_valid),
        .addr      (wr_addr),
        .wide      (wr_wide),
        .tgt_ready (wr_tgt_ready),
        .ready     (wr_ready),
        .mem_valid (mem_wr_valid),
        .mem_sel   (mem_wr_sel),
        .mem_addr  (mem_wr_addr),
        .accept    (wr_accept),
        .fault     (wr_fault)
    );

    assign mem_rd_wide = rd_wide;
    assign mem_wr_wide = wr_wide;

    rsp_state_t state_d, state_q;

    always_comb begin
        state_d           = state_q;
        state_d.rd_rvalid = rd_accept;
        state_d.rd_err    = rd_accept && rd_fault;
        state_d.wr_err    = wr_accept && wr_fault;
        if (rd_accept) begin
            state_d.rd_wide = rd_wide;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        rd_rvalid = state_q.rd_rvalid;
        rd_err    = state_q.rd_err;
        wr_err    = state_q.wr_err;
        rd_rdata  = '0;
        if (state_q.rd_rvalid && !state_q.rd_err) begin
            if (state_q.rd_wide) begin
                rd_rdata = mem_rd_data;
            end else begin
                rd_rdata[HALF_W-1:0] = mem_rd_data[HALF_W-1:0];
            end
        end
        mem_wr_data = wr_data;
        if (!wr_wide) begin
            mem_wr_data[DATA_W-1:HALF_W] = '0;
        end
    end

    // R8
    rd_resp_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready) |=> rd_rvalid);

    // R8
    rd_resp_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rvalid |-> $past(rd_valid && rd_ready));

    // R7
    rd_err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> (rd_rvalid && rd_rdata == '0));

    // R9
    rd_narrow_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready && !rd_wide) |=> (rd_rdata[DATA_W-1:HALF_W] == '0));

    // R5
    wr_err_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(wr_valid && wr_ready && !mem_wr_valid));

    // R1
    wr_indep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !mem_wr_valid) |-> wr_ready);

endmodule

// File: tb/cdb_access_unit_bench.sv
module cdb_access_unit_bench;

    typedef struct packed {
        logic [15:0] rd_addr;
        logic        rd_wide;
        logic [15:0] wr_addr;
        logic        wr_wide;
        logic [3:0]  exp_rsel;
        logic [15:0] exp_raddr;
        logic [3:0]  exp_wsel;
        logic [15:0] exp_waddr;
        logic        exp_rerr;
        logic        exp_werr;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{16'h1481, 1'b1, 16'h8003, 1'b1, 4'b0001, 16'h1480, 4'b0100, 16'h8002, 1'b0, 1'b0},
        '{16'h1501, 1'b0, 16'h1485, 1'b0, 4'b0010, 16'h1501, 4'b0001, 16'h1485, 1'b0, 1'b0},
        '{16'h8FFF, 1'b1, 16'h4001, 1'b1, 4'b0100, 16'h8FFE, 4'b1000, 16'h4000, 1'b0, 1'b0},
        '{16'h5FFF, 1'b0, 16'h1502, 1'b1, 4'b1000, 16'h5FFF, 4'b0000, 16'h1502, 1'b0, 1'b1},
        '{16'h0100, 1'b0, 16'hF001, 1'b1, 4'b0000, 16'h0100, 4'b0000, 16'hF000, 1'b1, 1'b1},
        '{16'h1500, 1'b1, 16'h9FFF, 1'b0, 4'b0010, 16'h1500, 4'b0100, 16'h9FFF, 1'b0, 1'b0},
        '{16'hA000, 1'b1, 16'h14FF, 1'b1, 4'b0000, 16'hA000, 4'b0001, 16'h14FE, 1'b1, 1'b0},
        '{16'h147F, 1'b0, 16'h1580, 1'b0, 4'b0000, 16'h147F, 4'b0000, 16'h1580, 1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_valid = 1'b0, rd_wide = 1'b0, wr_valid = 1'b0, wr_wide = 1'b0;
    logic [15:0] rd_addr = '0, wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_tgt_ready = 4'hF, wr_tgt_ready = 4'hF;
    logic [15:0] cap_addr = '0;
    logic [31:0] mem_rd_data;
    logic        rd_ready, rd_rvalid, rd_err, wr_ready, wr_err;
    logic [31:0] rd_rdata, mem_wr_data;
    logic        mem_rd_valid, mem_rd_wide, mem_wr_valid, mem_wr_wide;
    logic [3:0]  mem_rd_sel, mem_wr_sel;
    logic [15:0] mem_rd_addr, mem_wr_addr;

    int checks = 0;
    int failures = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    // memory model: data follows the accepted address one cycle later
    always @(posedge clk) begin
        if (mem_rd_valid && rd_ready) cap_addr <= mem_rd_addr;
    end
    assign mem_rd_data = {cap_addr ^ 16'hA5A5, cap_addr};

    cdb_access_unit u_cdb_access_unit (
        .clk (clk), .rst_n (rst_n),
        .rd_valid (rd_valid), .rd_ready (rd_ready), .rd_addr (rd_addr), .rd_wide (rd_wide),
        .rd_rvalid (rd_rvalid), .rd_rdata (rd_rdata), .rd_err (rd_err),
        .wr_valid (wr_valid), .wr_ready (wr_ready), .wr_addr (wr_addr), .wr_wide (wr_wide),
        .wr_data (wr_data), .wr_err (wr_err),
        .mem_rd_valid (mem_rd_valid), .mem_rd_sel (mem_rd_sel), .mem_rd_addr (mem_rd_addr),
        .mem_rd_wide (mem_rd_wide), .rd_tgt_ready (rd_tgt_ready), .mem_rd_data (mem_rd_data),
        .mem_wr_valid (mem_wr_valid), .mem_wr_sel (mem_wr_sel), .mem_wr_addr (mem_wr_addr),
        .mem_wr_wide (mem_wr_wide), .mem_wr_data (mem_wr_data), .wr_tgt_ready (wr_tgt_ready)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        check(act === exp, tag, act, exp);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11
        chk_eq("R11 rd_rvalid", {31'd0, rd_rvalid}, 32'd0);
        chk_eq("R11 rd_err", {31'd0, rd_err}, 32'd0);
        chk_eq("R11 wr_err", {31'd0, wr_err}, 32'd0);
        chk_eq("R11 rd_rdata", rd_rdata, 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            logic [31:0] exp_rd;
            logic [31:0] exp_wd;
            @(negedge clk);
            rd_valid = 1'b1; rd_addr = VECS[i].rd_addr; rd_wide = VECS[i].rd_wide;
            wr_valid = 1'b1; wr_addr = VECS[i].wr_addr; wr_wide = VECS[i].wr_wide;
            wr_data  = 32'hC3E1_0000 | i;
            exp_wd   = VECS[i].wr_wide ? wr_data : {16'h0, wr_data[15:0]};
            #1;
            // R1 R7: no stall with all targets ready, both accepted together
            chk_eq("R1 ready pair", {30'd0, rd_ready, wr_ready}, 32'd3);
            // R2 R3 R4
            chk_eq("R2 rd addr", {16'd0, mem_rd_addr}, {16'd0, VECS[i].exp_raddr});
            chk_eq("R3 rd sel", {28'd0, mem_rd_sel}, {28'd0, VECS[i].exp_rsel});
            chk_eq("R4 rd valid", {31'd0, mem_rd_valid}, {31'd0, |VECS[i].exp_rsel});
            chk_eq("R2 wr addr", {16'd0, mem_wr_addr}, {16'd0, VECS[i].exp_waddr});
            // R5
            chk_eq("R5 wr sel", {28'd0, mem_wr_sel}, {28'd0, VECS[i].exp_wsel});
            chk_eq("R5 wr valid", {31'd0, mem_wr_valid}, {31'd0, |VECS[i].exp_wsel});
            // R10
            chk_eq("R10 wr data", mem_wr_data, exp_wd);
            @(posedge clk);
            #1;
            if (VECS[i].exp_rerr) exp_rd = 32'd0;
            else if (VECS[i].rd_wide) exp_rd = {VECS[i].exp_raddr ^ 16'hA5A5, VECS[i].exp_raddr};
            else exp_rd = {16'd0, VECS[i].exp_raddr};
            // R8 R9 R7
            chk_eq("R8 rvalid", {31'd0, rd_rvalid}, 32'd1);
            chk_eq("R9 rdata", rd_rdata, exp_rd);
            chk_eq("R7 rd_err", {31'd0, rd_err}, {31'd0, VECS[i].exp_rerr});
            chk_eq("R7 wr_err", {31'd0, wr_err}, {31'd0, VECS[i].exp_werr});
        end

        @(negedge clk);
        rd_valid = 1'b0; wr_valid = 1'b0;
        #1;
        @(posedge clk);
        #1;
        // R8 R7: nothing accepted, pulses gone
        chk_eq("R8 rvalid idle", {31'd0, rd_rvalid}, 32'd0);
        chk_eq("R7 err pulse ends", {30'd0, rd_err, wr_err}, 32'd0);

        // R6 stall on local RAM read, R1 write to outbox proceeds
        @(negedge clk);
        rd_tgt_ready = 4'b1011;
        rd_valid = 1'b1; rd_addr = 16'h8005; rd_wide = 1'b1;
        wr_valid = 1'b1; wr_addr = 16'h1490; wr_wide = 1'b0;
        #1;
        chk_eq("R6 rd stalled", {31'd0, rd_ready}, 32'd0);
        chk_eq("R6 rd presented", {31'd0, mem_rd_valid}, 32'd1);
        chk_eq("R1 wr ready", {31'd0, wr_ready}, 32'd1);
        @(posedge clk);
        #1;
        chk_eq("R6 no response", {31'd0, rd_rvalid}, 32'd0);
        @(negedge clk);
        wr_valid = 1'b0;
        for (int k = 0; k < 2; k++) begin
            @(posedge clk);
            #1;
            chk_eq("R6 still no response", {31'd0, rd_rvalid}, 32'd0);
            chk_eq("R6 addr held", {16'd0, mem_rd_addr}, 32'h0000_8004);
        end
        @(negedge clk);
        rd_tgt_ready = 4'b1111;
        #1;
        chk_eq("R6 released", {31'd0, rd_ready}, 32'd1);
        @(posedge clk);
        #1;
        chk_eq("R8 late rvalid", {31'd0, rd_rvalid}, 32'd1);
        chk_eq("R8 late rdata", rd_rdata, {16'h8004 ^ 16'hA5A5, 16'h8004});

        // R6 busy region not targeted has no effect
        @(negedge clk);
        rd_tgt_ready = 4'b0111;
        rd_addr = 16'h8010; rd_wide = 1'b0;
        #1;
        chk_eq("R6 other busy", {31'd0, rd_ready}, 32'd1);

        // R7 forbidden write and unmapped read with every target busy
        @(negedge clk);
        rd_tgt_ready = 4'b0000; wr_tgt_ready = 4'b0000;
        rd_addr = 16'hE000; rd_wide = 1'b1;
        wr_valid = 1'b1; wr_addr = 16'h1510; wr_wide = 1'b1;
        #1;
        chk_eq("R7 no stall rd", {31'd0, rd_ready}, 32'd1);
        chk_eq("R7 no stall wr", {31'd0, wr_ready}, 32'd1);
        chk_eq("R5 inbox dropped", {31'd0, mem_wr_valid}, 32'd0);
        @(negedge clk);
        rd_valid = 1'b0; wr_valid = 1'b0;
        #1;
        chk_eq("R5 wr_err pulse", {31'd0, wr_err}, 32'd1);
        chk_eq("R7 rd zero", rd_rdata, 32'd0);
        @(posedge clk);
        #1;
        chk_eq("R7 wr_err one cycle", {31'd0, wr_err}, 32'd0);

        done = 1'b1;
        finish_run();
    end

endmodule